// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block holds a read-only array of 32-bit words and emits it one bit per rising clock edge. It serves as the boot source that feeds an SRAM-based FPGA its configuration stream. Reading starts at word 0 and goes up through the addresses. Within each word the most significant bit is sent first. A chip-select input (`ce_n`) enables the block. A second pin, `rst_oe`, does two jobs: in one level it resets the counters, and in the other it enables the output. Which level does which is fixed by a configuration word that sits one address past the end of the array.

The serial output is modelled as a value plus a drive enable. `data_en` high means the block is driving the line and `data_out` carries a valid bit. When `data_en` is low the line floats, and the block then holds `data_out` at 0. Flow control comes only from `ce_n` and the reset/enable pin. There is no ready input. Holding `ce_n` high is the only way to stall, and a stalled bit is presented again once `ce_n` returns low. After the last bit has gone out, the block stops driving and pulls its chain output `ceo_n` low, so the next memory in a cascade can take over.

Top module: `cfg_stream_rom`

## Requirements
- R1: While `ce_n` is low and the reset function is inactive, each rising edge moves to the next bit. Bit k of the stream is bit (31 - k mod 32) of word k/32. Word a holds SEED ^ (a * 32'h9E3779B9), truncated to 32 bits.
- R2: `data_en` is 1 only when all three hold: `ce_n` is low, the reset function is inactive, and the end of the array has not been reached. When `data_en` is 0, `data_out` is 0.
- R3: If the reset function is active at a rising edge, the word and bit counters go back to zero and the end-of-array state is cleared. The next bit presented is bit 31 of word 0.
- R4: While `ce_n` is high, the counters hold, `data_en` is 0 and `ceo_n` is 1. When `ce_n` falls again, the bit that was pending is presented.
- R5: The edge that consumes bit 0 of word DEPTH-1 sets end-of-array. From the following cycle, `ceo_n` is 0 and `data_en` is 0, and the counters no longer advance.
- R6: After end-of-array is set, `ceo_n` equals `ce_n` as long as the output enable is active. `ceo_n` is 1 whenever the reset function is active. Once a reset has cleared end-of-array, `ceo_n` stays 1 until the whole array has been read again.
- R7: If OVF_WORD is all ones, `rst_oe` = 1 selects reset. If OVF_WORD is all zeros, `rst_oe` = 0 selects reset and `rst_oe` = 1 enables the output.
- R8: Any OVF_WORD other than all zeros is decoded as active-high reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; one bit per rising edge |
| rst_n | input | 1 | Asynchronous chip-level reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined counter reset / output enable, polarity set by OVF_WORD |
| data_out | output | 1 | Current serial bit; 0 when not driven |
| data_en | output | 1 | Output drive enable (line floats when low) |
| ceo_n | output | 1 | Chain enable to the next memory, active low |

## Verification
The active-high instance is read from beginning to end through the whole array. A one-cycle `ce_n` stall is inserted every 37 bits, so the stalls land on different bit positions inside the words and on word boundaries. Any skipped or repeated bit then shows up as a mismatch in the arithmetic stream. After the end of the array, the test moves `ce_n` and the reset pin separately. This separates the three phases of `ceo_n` and confirms that the counters stop. It then resets in the middle of a stream to show that reading restarts at word 0. Two more instances are built with an all-zero and a mixed overflow word. On each, the same pin level is applied, and the test checks that it resets one instance and enables the other.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  localparam int unsigned CFG_W   = 32;
  localparam int unsigned CFG_BW  = $clog2(CFG_W);
  localparam logic [CFG_W-1:0] CFG_MULT = 32'h9E37_79B9;

  // Content of array word a for a given seed.
  function automatic logic [CFG_W-1:0] cfg_word(input int unsigned a,
                                                input logic [CFG_W-1:0] seed);
    logic [CFG_W-1:0] prod;
    prod = CFG_W'(a) * CFG_MULT;
    return seed ^ prod;
  endfunction
endpackage

// File: rtl/cfgrom_polarity.sv
module cfgrom_polarity
  import cfgrom_pkg::*;
(
  input  logic [CFG_W-1:0] ovf_word,
  input  logic             pin,
  output logic             reset_act
);
  logic active_low;

  // Only an all-zero word selects active-low; everything else is active-high.
  assign active_low = (ovf_word == '0);
  assign reset_act  = active_low ? ~pin : pin;
endmodule

// File: rtl/cfgrom_array.sv
module cfgrom_array
  import cfgrom_pkg::*;
#(
  parameter int unsigned      DEPTH    = 1134,
  parameter logic [CFG_W-1:0] SEED     = 32'h5A5A_1234,
  parameter logic [CFG_W-1:0] OVF_WORD = '1,
  localparam int unsigned     AW       = $clog2(DEPTH + 1)
)(
  input  logic [AW-1:0]     addr,
  input  logic [CFG_BW-1:0] bit_idx,
  output logic              bit_val,
  output logic [CFG_W-1:0]  ovf_word
);
  logic [CFG_W-1:0]  rom [DEPTH+1];
  logic [CFG_W-1:0]  cur_word;
  logic [CFG_BW-1:0] sel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = cfg_word(i, SEED);
  end
  assign rom[DEPTH] = OVF_WORD;

  assign ovf_word = rom[DEPTH];
  assign cur_word = rom[addr];
  // MSB first: counter value 0 selects bit CFG_W-1.
  assign sel      = CFG_BW'(CFG_W - 1) - bit_idx;
  assign bit_val  = cur_word[sel];
endmodule

// File: rtl/cfgrom_counter.sv
module cfgrom_counter
  import cfgrom_pkg::*;
#(
  parameter int unsigned  DEPTH = 1134,
  localparam int unsigned AW    = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  output logic [AW-1:0]     addr,
  output logic [CFG_BW-1:0] bit_idx,
  output logic              done
);
  localparam logic [AW-1:0]     LAST_A = AW'(DEPTH - 1);
  localparam logic [CFG_BW-1:0] LAST_B = CFG_BW'(CFG_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      bit_idx <= '0;
      done    <= 1'b0;
    end else if (clr) begin
      addr    <= '0;
      bit_idx <= '0;
      done    <= 1'b0;
    end else if (run && !done) begin
      if (bit_idx == LAST_B) begin
        bit_idx <= '0;
        if (addr == LAST_A) done <= 1'b1;
        else                addr <= addr + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0 && bit_idx == '0 && !done));

  // R4
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> ($stable(addr) && $stable(bit_idx) && $stable(done)));

  // R1
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !done && bit_idx != LAST_B) |=> (bit_idx == $past(bit_idx) + 1'b1));

  // R5
  end_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(addr) == LAST_A && $past(bit_idx) == LAST_B));
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom
  import cfgrom_pkg::*;
#(
  parameter int unsigned      DEPTH    = 1134,
  parameter logic [CFG_W-1:0] SEED     = 32'h5A5A_1234,
  parameter logic [CFG_W-1:0] OVF_WORD = '1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic rst_oe,
  output logic data_out,
  output logic data_en,
  output logic ceo_n
);
  localparam int unsigned AW = $clog2(DEPTH + 1);

  logic [AW-1:0]     addr;
  logic [CFG_BW-1:0] bit_idx;
  logic              done;
  logic              bit_val;
  logic [CFG_W-1:0]  ovf_word;
  logic              reset_act;
  logic              oe_act;

  cfgrom_array #(.DEPTH(DEPTH), .SEED(SEED), .OVF_WORD(OVF_WORD)) u_array (
    .addr     (addr),
    .bit_idx  (bit_idx),
    .bit_val  (bit_val),
    .ovf_word (ovf_word)
  );

  cfgrom_polarity u_pol (
    .ovf_word  (ovf_word),
    .pin       (rst_oe),
    .reset_act (reset_act)
  );

  cfgrom_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (reset_act),
    .run     (~ce_n),
    .addr    (addr),
    .bit_idx (bit_idx),
    .done    (done)
  );

  assign oe_act   = ~reset_act;
  assign data_en  = ~ce_n & oe_act & ~done;
  assign data_out = data_en & bit_val;
  assign ceo_n    = ~(done & oe_act) | ce_n;

  // R2
  drive_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> !ce_n);

  // R5
  chain_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ceo_n |-> (!data_en && !ce_n));
endmodule

// File: tb/cfg_stream_rom_bench.sv
`timescale 1ns/1ps
module cfg_stream_rom_bench;
  localparam int unsigned DEPTH = 3;
  localparam int unsigned NBITS = DEPTH * 32;
  localparam logic [31:0] SEED  = 32'hC3A5_0F1E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ce_a = 1'b1, pin_a = 1'b1;
  logic ce_b = 1'b1, pin_b = 1'b0;
  logic ce_c = 1'b1, pin_c = 1'b1;
  logic d_a, e_a, o_a, d_b, e_b, o_b, d_c, e_c, o_c;

  cfg_stream_rom #(.DEPTH(DEPTH), .SEED(SEED), .OVF_WORD(32'hFFFF_FFFF)) u_cfg_stream_rom (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_a), .rst_oe(pin_a),
    .data_out(d_a), .data_en(e_a), .ceo_n(o_a));
  cfg_stream_rom #(.DEPTH(DEPTH), .SEED(SEED), .OVF_WORD(32'h0000_0000)) u_low (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_b), .rst_oe(pin_b),
    .data_out(d_b), .data_en(e_b), .ceo_n(o_b));
  cfg_stream_rom #(.DEPTH(DEPTH), .SEED(SEED), .OVF_WORD(32'h0000_FFFF)) u_odd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_c), .rst_oe(pin_c),
    .data_out(d_c), .data_en(e_c), .ceo_n(o_c));

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  function automatic logic exp_bit(input int k);
    logic [31:0] w;
    w = SEED ^ (32'(k / 32) * 32'h9E37_79B9);
    return w[31 - (k % 32)];
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #1000us;
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R4 reset state data_en", e_a, 1'b0);
    chk("R4 reset state ceo_n", o_a, 1'b1);
    rst_n = 1'b1;

    // R7: active-high instance held off with pin high
    ce_a = 1'b0;
    step();
    chk("R7 pin=1 resets active-high", e_a, 1'b0);
    chk("R6 ceo_n high during reset", o_a, 1'b1);
    pin_a = 1'b0;
    #1;

    // R1 full sweep with stalls (R4)
    for (int k = 0; k < NBITS; k++) begin
      chk($sformatf("R1 bit %0d", k), d_a, exp_bit(k));
      chk("R2 driven while enabled", e_a, 1'b1);
      chk("R6 ceo_n high while reading", o_a, 1'b1);
      if (k % 37 == 5) begin
        ce_a = 1'b1;
        step();
        chk("R4 stall data_en", e_a, 1'b0);
        chk("R2 stall data_out", d_a, 1'b0);
        chk("R4 stall ceo_n", o_a, 1'b1);
        ce_a = 1'b0;
        #1;
        chk($sformatf("R4 resume bit %0d", k), d_a, exp_bit(k));
      end
      step();
    end

    // R5 end of array
    chk("R5 ceo_n low after last bit", o_a, 1'b0);
    chk("R5 released after last bit", e_a, 1'b0);
    ce_a = 1'b1;
    #1;
    chk("R6 ceo_n follows ce_n high", o_a, 1'b1);
    ce_a = 1'b0;
    #1;
    chk("R6 ceo_n follows ce_n low", o_a, 1'b0);
    repeat (4) step();
    chk("R5 no advance past end", e_a, 1'b0);
    chk("R6 ceo_n stays low", o_a, 1'b0);
    pin_a = 1'b1;
    #1;
    chk("R6 ceo_n high on OE inactive", o_a, 1'b1);
    step();
    pin_a = 1'b0;
    #1;
    chk("R6 ceo_n stays high after reset", o_a, 1'b1);
    chk("R3 restart driven", e_a, 1'b1);
    chk("R3 restart bit 0", d_a, exp_bit(0));

    // R3 mid-stream reset
    for (int k = 0; k < 45; k++) begin
      chk($sformatf("R1 reread bit %0d", k), d_a, exp_bit(k));
      step();
    end
    pin_a = 1'b1;
    step();
    pin_a = 1'b0;
    #1;
    chk("R3 mid-stream reset bit 0", d_a, exp_bit(0));
    chk("R6 ceo_n high mid-stream", o_a, 1'b1);

    // R7 active-low instance
    ce_b = 1'b0;
    pin_b = 1'b0;
    #1;
    chk("R7 pin=0 resets active-low", e_b, 1'b0);
    step();
    pin_b = 1'b1;
    #1;
    chk("R7 pin=1 enables active-low", e_b, 1'b1);
    for (int k = 0; k < 3; k++) begin
      chk($sformatf("R7 active-low bit %0d", k), d_b, exp_bit(k));
      step();
    end
    pin_b = 1'b0;
    #1;
    chk("R7 pin=0 releases active-low", e_b, 1'b0);
    step();
    pin_b = 1'b1;
    #1;
    chk("R7 active-low restart bit 0", d_b, exp_bit(0));

    // R8 mixed overflow word behaves active-high
    ce_c = 1'b0;
    pin_c = 1'b1;
    #1;
    chk("R8 pin=1 resets mixed word", e_c, 1'b0);
    step();
    pin_c = 1'b0;
    #1;
    chk("R8 pin=0 enables mixed word", e_c, 1'b1);
    chk("R8 bit 0", d_c, exp_bit(0));
    step();
    chk("R8 bit 1", d_c, exp_bit(1));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule